// File: doc/BRIEF.md
# Genetic Pipeline Run Controller

This block sequences one run of a hardware genetic-algorithm pipeline and is the pipeline's only contact with the host and with shared storage. The host preloads the run settings into a parameter area of a shared synchronous RAM and then raises a start level. The controller sends a one-cycle start pulse to its four worker units: the fitness evaluator, the crossover/mutation unit, the random source and the population sequencer. It then holds a run enable for them.

While the run lasts, the controller is the single master of the RAM port. It serves three kinds of traffic. Write-backs come from the fitness evaluator, population reads come from the sequencer, and every worker sends parameter fetches that name the wanted setting by a small index. One request wins each cycle under a fixed priority. Read data comes back one cycle after the grant, with a one-hot tag that names the client it belongs to.

When the fitness evaluator reports that the run has converged, the controller drops the run enable and raises a stop line to the workers. One cycle later it signals completion to the host. It keeps that completion flag up until the host withdraws its start level.

Top module: `ga_run_ctrl`

## Requirements
- R1: After reset all outputs are low. In any state other than running, no request is granted and the RAM port stays disabled (`mem_en_o` low), even with requests pending.
- R2: When `go_i` is sampled high while idle, all four bits of `wrk_start_o` are high for exactly the next cycle. `wrk_en_o` is high from the cycle after that pulse.
- R3: A granted parameter fetch reads RAM address `PRM_BASE + index`. The index codes are 0 population size, 1 crossover threshold, 2 mutation threshold, 3 generation limit and 4 random seed.
- R4: A granted sequencer read uses address `POP_BASE + sq_addr_i`. A granted fitness write drives `mem_we_o` high, address `POP_BASE + fw_addr_i` and data `fw_data_i`, and a later read of that address returns the written word.
- R5: In the cycle after a read grant, `rd_vld_o` is one-hot and `rd_data_o` carries the RAM word. Bit u of `rd_vld_o` marks parameter unit u (0 fitness, 1 crossover/mutation, 2 random source, 3 sequencer), and bit 4 marks a sequencer population read. In cycles not preceded by a read grant, `rd_vld_o` is zero.
- R6: At most one grant is active per cycle. A fitness write beats a sequencer read, which beats any parameter fetch. Among parameter fetches the lowest unit number wins.
- R7: When `fit_done_i` is sampled high while running, the next cycle has `wrk_en_o` low and `wrk_stop_o` high. `done_o` rises one cycle later, stays high while `go_i` is high, and clears in the cycle after `go_i` is sampled low, which also returns the controller to idle.
- R8: A rising `go_i` while running produces no start pulse and leaves `wrk_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Host start level |
| done_o | output | 1 | Run finished, held until `go_i` drops |
| wrk_start_o | output | NUNIT | One-cycle start pulse, one bit per worker |
| wrk_en_o | output | 1 | Workers may run |
| wrk_stop_o | output | 1 | Workers shut down |
| fit_done_i | input | 1 | Fitness evaluator reports run complete |
| fw_req_i | input | 1 | Fitness write-back request |
| fw_addr_i | input | PW | Population slot to write |
| fw_data_i | input | DW | Member to write |
| fw_gnt_o | output | 1 | Write-back granted |
| sq_req_i | input | 1 | Sequencer population read request |
| sq_addr_i | input | PW | Population slot to read |
| sq_gnt_o | output | 1 | Sequencer read granted |
| prm_req_i | input | NUNIT | Parameter fetch request per unit |
| prm_idx_i | input | NUNIT x IW | Parameter index per unit |
| prm_gnt_o | output | NUNIT | Parameter fetch granted per unit |
| rd_vld_o | output | NUNIT+1 | One-hot read-return tag |
| rd_data_o | output | DW | Read-return data |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, one cycle after access |

## Verification
A wrong run state shows at the ports within one cycle. It would appear as a start pulse outside an idle-to-run step, as a grant while the run enable is low, or as `done_o` without a preceding stop cycle. A fault in the arbiter or address mux shows in the same cycle as the grant, as two grants or a wrong RAM address. A fault in the return path shows one cycle later, as a wrong one-hot tag or a word that differs from the arithmetic RAM contents. The sweeps cover every index for every unit and every population slot.

// File: rtl/ga_ctrl_pkg.sv
package ga_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NOTIFY = 2'd1,
    ST_RUN    = 2'd2,
    ST_SHUT   = 2'd3
  } run_state_e;

  // Parameter indices inside the parameter area
  localparam int unsigned PIX_POPSIZE = 0;
  localparam int unsigned PIX_XOVER   = 1;
  localparam int unsigned PIX_MUTATE  = 2;
  localparam int unsigned PIX_GENLIM  = 3;
  localparam int unsigned PIX_SEED    = 4;
  localparam int unsigned NUM_PRM     = 5;

  // Address of an entry inside a RAM region
  function automatic int unsigned region_addr(input int unsigned base,
                                              input int unsigned ofs);
    return base + ofs;
  endfunction

endpackage

// File: rtl/ga_ctrl_fsm.sv
module ga_ctrl_fsm
  import ga_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       fit_done_i,
  output run_state_e state_o,
  output logic       done_o
);

  run_state_e st_q, st_d;
  logic       done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (go_i) st_d = ST_NOTIFY;
      ST_NOTIFY: st_d = ST_RUN;
      ST_RUN:    if (fit_done_i) st_d = ST_SHUT;
      ST_SHUT:   if (done_q && !go_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      // done follows the first shutdown cycle and holds until exit
      done_q <= (st_q == ST_SHUT) && (st_d == ST_SHUT);
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;

endmodule

// File: rtl/ga_ctrl_arb.sv
module ga_ctrl_arb #(
  parameter int unsigned NUNIT = 4
) (
  input  logic             en_i,
  input  logic             fw_req_i,
  input  logic             sq_req_i,
  input  logic [NUNIT-1:0] prm_req_i,
  output logic             fw_gnt_o,
  output logic             sq_gnt_o,
  output logic [NUNIT-1:0] prm_gnt_o
);

  logic [NUNIT-1:0] taken;

  assign fw_gnt_o = en_i & fw_req_i;
  assign sq_gnt_o = en_i & sq_req_i & ~fw_req_i;
  assign taken[0] = ~en_i | fw_req_i | sq_req_i;

  for (genvar u = 0; u < NUNIT; u++) begin : g_prm
    assign prm_gnt_o[u] = prm_req_i[u] & ~taken[u];
    if (u < NUNIT - 1) begin : g_chain
      assign taken[u+1] = taken[u] | prm_req_i[u];
    end
  end

endmodule

// File: rtl/ga_ctrl_resp.sv
module ga_ctrl_resp #(
  parameter int unsigned NCLI = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLI-1:0] rd_gnt_i,
  output logic [NCLI-1:0] rd_vld_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld_o <= '0;
    else        rd_vld_o <= rd_gnt_i;
  end

endmodule

// File: rtl/ga_run_ctrl.sv
module ga_run_ctrl
  import ga_ctrl_pkg::*;
#(
  parameter int unsigned NUNIT    = 4,
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter int unsigned PW       = 6,
  parameter int unsigned IW       = 3,
  parameter int unsigned POP_BASE = 0,
  parameter int unsigned PRM_BASE = 200
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go_i,
  output logic                      done_o,
  output logic [NUNIT-1:0]          wrk_start_o,
  output logic                      wrk_en_o,
  output logic                      wrk_stop_o,
  input  logic                      fit_done_i,
  input  logic                      fw_req_i,
  input  logic [PW-1:0]             fw_addr_i,
  input  logic [DW-1:0]             fw_data_i,
  output logic                      fw_gnt_o,
  input  logic                      sq_req_i,
  input  logic [PW-1:0]             sq_addr_i,
  output logic                      sq_gnt_o,
  input  logic [NUNIT-1:0]          prm_req_i,
  input  logic [NUNIT-1:0][IW-1:0]  prm_idx_i,
  output logic [NUNIT-1:0]          prm_gnt_o,
  output logic [NUNIT:0]            rd_vld_o,
  output logic [DW-1:0]             rd_data_o,
  output logic                      mem_en_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [DW-1:0]             mem_wdata_o,
  input  logic [DW-1:0]             mem_rdata_i
);

  localparam int unsigned NCLI = NUNIT + 1;

  run_state_e      st;
  logic [NCLI-1:0] rd_gnt;
  logic            any_gnt;
  logic [IW-1:0]   sel_idx;

  ga_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_i),
    .fit_done_i (fit_done_i),
    .state_o    (st),
    .done_o     (done_o)
  );

  assign wrk_start_o = {NUNIT{st == ST_NOTIFY}};
  assign wrk_en_o    = (st == ST_RUN);
  assign wrk_stop_o  = (st == ST_SHUT);

  ga_ctrl_arb #(.NUNIT(NUNIT)) u_arb (
    .en_i      (wrk_en_o),
    .fw_req_i  (fw_req_i),
    .sq_req_i  (sq_req_i),
    .prm_req_i (prm_req_i),
    .fw_gnt_o  (fw_gnt_o),
    .sq_gnt_o  (sq_gnt_o),
    .prm_gnt_o (prm_gnt_o)
  );

  assign rd_gnt  = {sq_gnt_o, prm_gnt_o};
  assign any_gnt = fw_gnt_o | (|rd_gnt);

  always_comb begin
    sel_idx = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (prm_gnt_o[u]) sel_idx = prm_idx_i[u];
    end
  end

  always_comb begin
    mem_addr_o = '0;
    if (fw_gnt_o)
      mem_addr_o = AW'(region_addr(POP_BASE, 32'(fw_addr_i)));
    else if (sq_gnt_o)
      mem_addr_o = AW'(region_addr(POP_BASE, 32'(sq_addr_i)));
    else if (|prm_gnt_o)
      mem_addr_o = AW'(region_addr(PRM_BASE, 32'(sel_idx)));
  end

  assign mem_en_o    = any_gnt;
  assign mem_we_o    = fw_gnt_o;
  assign mem_wdata_o = fw_data_i;

  ga_ctrl_resp #(.NCLI(NCLI)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_gnt_i (rd_gnt),
    .rd_vld_o (rd_vld_o)
  );

  assign rd_data_o = mem_rdata_i;

endmodule

// File: rtl/ga_run_ctrl_chk.sv
module ga_run_ctrl_chk
  import ga_ctrl_pkg::*;
#(
  parameter int unsigned NUNIT    = 4,
  parameter int unsigned AW       = 8,
  parameter int unsigned PRM_BASE = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_i,
  input logic             done_o,
  input logic [NUNIT-1:0] wrk_start_o,
  input logic             wrk_en_o,
  input logic             wrk_stop_o,
  input logic             fw_req_i,
  input logic             fw_gnt_o,
  input logic             sq_gnt_o,
  input logic [NUNIT-1:0] prm_gnt_o,
  input logic [NUNIT:0]   rd_vld_o,
  input logic             mem_en_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input run_state_e       st
);

  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrk_en_o |-> (!mem_en_o && !fw_gnt_o && !sq_gnt_o && prm_gnt_o == '0));

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrk_start_o) |=> (wrk_start_o == '0) && wrk_en_o);

  assert_prm_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|prm_gnt_o) |-> (!mem_we_o && mem_addr_o >= AW'(PRM_BASE)));

  assert_vld_after_gnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_gnt_o || (|prm_gnt_o)) |=> $onehot(rd_vld_o));

  assert_no_stray_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_gnt_o || (|prm_gnt_o)) |=> (rd_vld_o == '0));

  assert_single_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fw_gnt_o, sq_gnt_o, prm_gnt_o}));

  assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrk_en_o && fw_req_i) |-> fw_gnt_o);

  assert_stop_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (wrk_stop_o && $past(wrk_stop_o)));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && go_i) |=> done_o);

  assert_go_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && go_i) |=> (wrk_start_o == '0));

endmodule

bind ga_run_ctrl ga_run_ctrl_chk #(
  .NUNIT    (NUNIT),
  .AW       (AW),
  .PRM_BASE (PRM_BASE)
) u_chk (.*);

// File: tb/ga_run_ctrl_tb.sv
`timescale 1ns/1ps
module ga_run_ctrl_tb;

  localparam int NU = 4;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int PW = 6;
  localparam int IW = 3;
  localparam int PB = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, fit_done = 1'b0;
  logic done, wen, wstop;
  logic [NU-1:0] wstart;
  logic fw_req = 1'b0, sq_req = 1'b0;
  logic [PW-1:0] fw_addr = '0, sq_addr = '0;
  logic [DW-1:0] fw_data = '0;
  logic fw_gnt, sq_gnt;
  logic [NU-1:0] prm_req = '0;
  logic [NU-1:0][IW-1:0] prm_idx = '0;
  logic [NU-1:0] prm_gnt;
  logic [NU:0] rd_vld;
  logic [DW-1:0] rd_data;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] ram [256];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ga_run_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .done_o(done),
    .wrk_start_o(wstart), .wrk_en_o(wen), .wrk_stop_o(wstop),
    .fit_done_i(fit_done),
    .fw_req_i(fw_req), .fw_addr_i(fw_addr), .fw_data_i(fw_data), .fw_gnt_o(fw_gnt),
    .sq_req_i(sq_req), .sq_addr_i(sq_addr), .sq_gnt_o(sq_gnt),
    .prm_req_i(prm_req), .prm_idx_i(prm_idx), .prm_gnt_o(prm_gnt),
    .rd_vld_o(rd_vld), .rd_data_o(rd_data),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [DW-1:0] exp_word(input int a);
    return DW'((a * 613 + 91) ^ (a << 7));
  endfunction

  // Synchronous RAM model, loaded arithmetically during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= exp_word(i);
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic prm_fetch(input int u, input int idx);
    @(negedge clk);
    prm_req[u] = 1'b1;
    prm_idx[u] = IW'(idx);
    #1;
    check(prm_gnt == NU'(1 << u), "R6 prm grant", int'(prm_gnt), 1 << u);
    check(mem_en && !mem_we && mem_addr == AW'(PB + idx), "R3 prm addr", int'(mem_addr), PB + idx);
    @(negedge clk);
    prm_req[u] = 1'b0;
    #1;
    check(rd_vld == (NU+1)'(1 << u), "R5 prm tag", int'(rd_vld), 1 << u);
    check(rd_data == exp_word(PB + idx), "R5 prm data", int'(rd_data), int'(exp_word(PB + idx)));
  endtask

  task automatic seq_read(input int a, input logic [DW-1:0] expd);
    @(negedge clk);
    sq_req = 1'b1;
    sq_addr = PW'(a);
    #1;
    check(sq_gnt && mem_en && !mem_we && mem_addr == AW'(a), "R4 seq addr", int'(mem_addr), a);
    @(negedge clk);
    sq_req = 1'b0;
    #1;
    check(rd_vld == (NU+1)'(1 << NU), "R5 seq tag", int'(rd_vld), 1 << NU);
    check(rd_data == expd, "R4 seq data", int'(rd_data), int'(expd));
  endtask

  task automatic fit_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    fw_req = 1'b1;
    fw_addr = PW'(a);
    fw_data = d;
    #1;
    check(fw_gnt && mem_we && mem_addr == AW'(a) && mem_wdata == d, "R4 write port", int'(mem_wdata), int'(d));
    @(negedge clk);
    fw_req = 1'b0;
    #1;
    check(rd_vld == '0, "R5 no tag after write", int'(rd_vld), 0);
  endtask

  task automatic start_run(input string tag);
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    #1;
    check(wstart == '1 && !wen, {tag, " start pulse"}, int'(wstart), 15);
    @(negedge clk);
    #1;
    check(wstart == '0 && wen, {tag, " pulse ends, run on"}, int'(wstart), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(!done && !wen && !wstop && wstart == '0 && rd_vld == '0, "R1 reset outputs",
          int'({done, wen, wstop, wstart}), 0);
    // R1: requests while idle are not served
    sq_req = 1'b1;
    prm_req = 4'b0001;
    fw_req = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check(!mem_en && !fw_gnt && !sq_gnt && prm_gnt == '0, "R1 idle no grant",
            int'({mem_en, fw_gnt, sq_gnt, prm_gnt}), 0);
    end
    sq_req = 1'b0; prm_req = '0; fw_req = 1'b0;

    start_run("R2");
    go = 1'b0;

    // R3/R5: every index for every unit
    for (int u = 0; u < NU; u++)
      for (int idx = 0; idx < 5; idx++)
        prm_fetch(u, idx);

    // R4: full population sweep
    for (int a = 0; a < 64; a++) seq_read(a, exp_word(a));

    // R4: write-back then read-back
    for (int k = 0; k < 4; k++) begin
      int a = k * 21;
      logic [DW-1:0] d = DW'(16'hA5C3 ^ (a * 257));
      fit_write(a, d);
      seq_read(a, d);
    end

    // R6: priority order with everyone requesting
    @(negedge clk);
    fw_req = 1'b1; fw_addr = PW'(9); fw_data = 16'h1234;
    sq_req = 1'b1; sq_addr = PW'(3);
    prm_req = '1;
    for (int u = 0; u < NU; u++) prm_idx[u] = IW'(u);
    #1;
    check(fw_gnt && !sq_gnt && prm_gnt == '0, "R6 write wins", int'({fw_gnt, sq_gnt, prm_gnt}), 32);
    @(negedge clk);
    fw_req = 1'b0;
    #1;
    check(!fw_gnt && sq_gnt && prm_gnt == '0, "R6 seq next", int'({fw_gnt, sq_gnt, prm_gnt}), 16);
    @(negedge clk);
    sq_req = 1'b0;
    for (int u = 0; u < NU; u++) begin
      #1;
      check(!fw_gnt && !sq_gnt && prm_gnt == NU'(1 << u), "R6 lowest unit wins",
            int'(prm_gnt), 1 << u);
      @(negedge clk);
      prm_req[u] = 1'b0;
    end

    // R8: go pulse during run is ignored
    go = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check(wstart == '0 && wen && !done, "R8 go ignored", int'({wstart, wen}), 1);
    end

    // R7: completion with go still high
    fit_done = 1'b1;
    @(negedge clk);
    fit_done = 1'b0;
    sq_req = 1'b1;
    #1;
    check(wstop && !wen && !done, "R7 stop first", int'({wstop, wen, done}), 4);
    check(!sq_gnt && !mem_en, "R1 no grant in shutdown", int'({sq_gnt, mem_en}), 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check(done && wstop, "R7 done held", int'({done, wstop}), 3);
    end
    sq_req = 1'b0;
    go = 1'b0;
    #1;
    check(done, "R7 done until go sampled low", int'(done), 1);
    @(negedge clk);
    #1;
    check(!done && !wstop && !wen && wstart == '0, "R7 back to idle",
          int'({done, wstop, wen, wstart}), 0);

    // R2: a second run starts cleanly
    start_run("R2 restart");
    go = 1'b0;
    prm_fetch(2, 4);

    report();
  end

endmodule